// File: doc/BRIEF.md
# DMA Transfer Count Engine

This block runs the data phase of a storage-bus controller. Software first programs a 24-bit transfer count. A start command then launches a burst that moves bytes between a memory-side stream and a target-side stream. The direction comes from the sign of the pending target length. A negative length moves bytes from memory toward the target. A zero or positive length moves bytes from the target into memory. During command collection the bytes always flow toward the target, and a burst never exceeds 32 bytes.

The count register counts down by one for each byte that moves, so reading it mid-transfer shows what is left. When a burst ends, the engine either finishes at once or waits for the next target-chunk event or a command-complete event. Finishing updates the status, interrupt, sequence-step and flags registers, clears the count and raises the interrupt. An enable input lets the system hold a started command until DMA is allowed. Once enable is high, the held command runs with the settings in place at that moment.

Top module: `dte_engine`

## Requirements
- R1: A programmed count of zero launches as a transfer length of 65536, and `cnt_q` reads 0x10000 in the cycle after launch.
- R2: Outside command phase, the burst is the smaller of the transfer length and the magnitude of `pend_len`. The engine moves exactly that many bytes and `cnt_q` falls by the same amount.
- R3: With `cmd_phase` high, the burst is the smaller of the transfer length and 32. Bytes flow memory to target. When the burst ends, the transfer completes in the next cycle.
- R4: A negative `pend_len` (two's complement) routes bytes from `mem_in` to `tgt_out`. Any other value routes them from `tgt_in` to `mem_out`. The unused input stream is never made ready.
- R5: Each accepted byte lowers `cnt_q` by one. Bytes leave with their values unchanged and in their arrival order.
- R6: Launch clears the terminal-count bit `stat_q[4]`. It also writes the phase field `stat_q[2:0]`: 000 for data to the target, 001 for data from the target, 010 for command.
- R7: Completion sets `stat_q[4]`, writes 0x10 to `intr_q`, zeroes `seq_q`, `flags_q` and `cnt_q`, and raises `irq`.
- R8: A from-target burst that ends while the pending length is still nonzero completes in the cycle after the last byte.
- R9: A to-target burst, or one that used up the pending length, stays busy with no interrupt. It completes on `chunk_evt` or `cmd_done`.
- R10: While the source stream offers no byte, the engine waits: it stays busy, `cnt_q` holds, and `irq` stays low.
- R11: A `start` taken while `dma_en` is low is held and nothing is launched. No byte moves while `dma_en` is low. The held start launches in the cycle after `dma_en` rises.
- R12: `cmd_done` clears the pending length and runs completion with `stat_q` = 0x13 (status phase 011 plus terminal count).
- R13: `irq_ack` lowers `irq`, clears `intr_q` and clears `stat_q[4]`.
- R14: A `cnt_wr` while the engine is busy (held, running or deferred) leaves `cnt_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Write the transfer count (accepted when idle) |
| cnt_wdata | input | 24 | Transfer count value |
| start | input | 1 | Start a DMA transfer |
| cmd_phase | input | 1 | Command collection mode (32-byte cap, toward target) |
| dma_en | input | 1 | DMA allowed |
| pend_len | input | 20 | Signed pending target length; sign selects direction |
| cmd_done | input | 1 | Command-complete event |
| chunk_evt | input | 1 | Next target chunk event; releases a deferred completion |
| irq_ack | input | 1 | Acknowledge and clear the interrupt |
| aux_wr | input | 1 | Load sequence-step and flags |
| aux_seq | input | 3 | Sequence-step load value |
| aux_flags | input | 5 | Flags load value |
| mem_in_valid | input | 1 | Memory-side byte offered (to-target direction) |
| mem_in_data | input | 8 | Memory-side byte |
| mem_in_ready | output | 1 | Memory-side byte accepted |
| tgt_out_valid | output | 1 | Byte offered to target |
| tgt_out_data | output | 8 | Byte to target |
| tgt_out_ready | input | 1 | Target accepts byte |
| tgt_in_valid | input | 1 | Target byte offered (from-target direction) |
| tgt_in_data | input | 8 | Target byte |
| tgt_in_ready | output | 1 | Target byte accepted |
| mem_out_valid | output | 1 | Byte offered to memory |
| mem_out_data | output | 8 | Byte to memory |
| mem_out_ready | input | 1 | Memory accepts byte |
| cnt_q | output | 24 | Remaining transfer count |
| stat_q | output | 8 | Status: bit 4 terminal count, bits 2:0 phase |
| intr_q | output | 8 | Interrupt cause |
| seq_q | output | 3 | Sequence step |
| flags_q | output | 5 | Flags |
| irq | output | 1 | Interrupt request |

## Verification
Four properties are checked on every cycle:
- each accepted byte lowers the count by exactly one;
- no byte moves while DMA is disabled;
- the two stream directions are never ready together, and terminal count stays clear while bytes move;
- every rising interrupt carries the full completion register image.

Other behaviours only show up in the bench scenarios. These are the burst lengths chosen from the count, the pending length and the command-phase cap, and the zero-means-65536 rule. The scenarios also show which burst endings complete at once and which wait for a chunk or command-complete event. The replay of a held start and the byte ordering through the scoreboard are likewise covered only there.

// File: rtl/dte_pkg.sv
`timescale 1ns/1ps
package dte_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HELD  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DEFER = 2'd3
  } dte_state_e;

  localparam logic [7:0] INTR_BUS_SVC = 8'h10;
  localparam logic [7:0] STAT_TC      = 8'h10;
  localparam logic [2:0] PH_DOUT      = 3'b000;
  localparam logic [2:0] PH_DIN       = 3'b001;
  localparam logic [2:0] PH_CMD       = 3'b010;
  localparam logic [2:0] PH_STATUS    = 3'b011;
endpackage

// File: rtl/dte_len_calc.sv
`timescale 1ns/1ps
module dte_len_calc #(
  parameter int CNT_W    = 24,
  parameter int PEND_W   = 20,
  parameter int CMD_MAX  = 32,
  parameter int ZERO_LEN = 65536
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [PEND_W-1:0] pend,
  input  logic              cmd_phase,
  output logic [CNT_W-1:0]  xfer_len,
  output logic [CNT_W-1:0]  burst_len,
  output logic [PEND_W-1:0] pend_mag,
  output logic              to_tgt
);
  localparam int CMP_W = (CNT_W > PEND_W) ? CNT_W : PEND_W;

  logic [CMP_W-1:0] len_w;
  logic [CMP_W-1:0] lim_w;

  always_comb begin
    xfer_len  = (cnt == '0) ? CNT_W'(ZERO_LEN) : cnt;
    pend_mag  = pend[PEND_W-1] ? (~pend + 1'b1) : pend;
    to_tgt    = cmd_phase | pend[PEND_W-1];
    len_w     = CMP_W'(xfer_len);
    lim_w     = cmd_phase ? CMP_W'(CMD_MAX) : CMP_W'(pend_mag);
    burst_len = CNT_W'((lim_w < len_w) ? lim_w : len_w);
  end
endmodule

// File: rtl/dte_mover.sv
`timescale 1ns/1ps
module dte_mover #(
  parameter int DATA_W = 8
) (
  input  logic              act,
  input  logic              to_tgt,
  input  logic              mem_in_valid,
  input  logic [DATA_W-1:0] mem_in_data,
  output logic              mem_in_ready,
  output logic              tgt_out_valid,
  output logic [DATA_W-1:0] tgt_out_data,
  input  logic              tgt_out_ready,
  input  logic              tgt_in_valid,
  input  logic [DATA_W-1:0] tgt_in_data,
  output logic              tgt_in_ready,
  output logic              mem_out_valid,
  output logic [DATA_W-1:0] mem_out_data,
  input  logic              mem_out_ready,
  output logic              xfer
);
  logic path_out;
  logic path_in;

  always_comb begin
    path_out      = act & to_tgt;
    path_in       = act & ~to_tgt;
    tgt_out_valid = path_out & mem_in_valid;
    mem_in_ready  = path_out & tgt_out_ready;
    tgt_out_data  = mem_in_data;
    mem_out_valid = path_in & tgt_in_valid;
    tgt_in_ready  = path_in & mem_out_ready;
    mem_out_data  = tgt_in_data;
    xfer          = (tgt_out_valid & tgt_out_ready) | (mem_out_valid & mem_out_ready);
  end
endmodule

// File: rtl/dte_ctrl.sv
`timescale 1ns/1ps
module dte_ctrl
  import dte_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PEND_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dma_en,
  input  logic              cmd_done,
  input  logic              chunk_evt,
  input  logic              xfer,
  input  logic              cmd_phase,
  input  logic              to_tgt_in,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [PEND_W-1:0] pend_mag,
  output logic              launch,
  output logic              complete,
  output logic              busy,
  output logic              run_act,
  output logic              to_tgt_q
);
  dte_state_e        state_q, state_d;
  logic [CNT_W-1:0]  burst_q, burst_d;
  logic [PEND_W-1:0] pendl_q, pendl_d;
  logic              cmd_q;
  logic              burst_en, pendl_en;

  always_comb begin
    state_d  = state_q;
    launch   = 1'b0;
    complete = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (dma_en) begin
            launch  = 1'b1;
            state_d = ST_RUN;
          end else begin
            state_d = ST_HELD;
          end
        end
      end
      ST_HELD: begin
        if (dma_en) begin
          launch  = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (burst_q == '0) begin
          if (cmd_q || (!to_tgt_q && pendl_q != '0)) begin
            complete = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            state_d = ST_DEFER;
          end
        end
      end
      ST_DEFER: begin
        if (chunk_evt) begin
          complete = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (cmd_done) begin
      complete = 1'b1;
      launch   = 1'b0;
      state_d  = ST_IDLE;
    end
  end

  always_comb begin
    busy    = (state_q != ST_IDLE);
    run_act = (state_q == ST_RUN) && dma_en && (burst_q != '0) && !cmd_done;

    burst_en = launch | xfer;
    burst_d  = launch ? burst_len : (burst_q - 1'b1);

    pendl_en = cmd_done | launch | (xfer & ~cmd_q & (pendl_q != '0));
    if (cmd_done)    pendl_d = '0;
    else if (launch) pendl_d = pend_mag;
    else             pendl_d = pendl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      burst_q  <= '0;
      pendl_q  <= '0;
      cmd_q    <= 1'b0;
      to_tgt_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (burst_en) burst_q <= burst_d;
      if (pendl_en) pendl_q <= pendl_d;
      if (launch) begin
        cmd_q    <= cmd_phase;
        to_tgt_q <= to_tgt_in;
      end
    end
  end
endmodule

// File: rtl/dte_regs.sv
`timescale 1ns/1ps
module dte_regs
  import dte_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             busy,
  input  logic             launch,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic [2:0]       launch_phase,
  input  logic             xfer,
  input  logic             complete,
  input  logic             cmd_done,
  input  logic             irq_ack,
  input  logic             aux_wr,
  input  logic [2:0]       aux_seq,
  input  logic [4:0]       aux_flags,
  output logic [CNT_W-1:0] cnt_q,
  output logic [7:0]       stat_q,
  output logic [7:0]       intr_q,
  output logic [2:0]       seq_q,
  output logic [4:0]       flags_q,
  output logic             irq
);
  logic             wr_ok;
  logic [CNT_W-1:0] cnt_d;
  logic [7:0]       stat_d, intr_d;
  logic [2:0]       seq_d;
  logic [4:0]       flags_d;
  logic             irq_d;
  logic             cnt_en, stat_en, intr_en, aux_en;

  always_comb begin
    wr_ok = cnt_wr & ~busy;

    cnt_en = complete | launch | xfer | wr_ok;
    if (complete)    cnt_d = '0;
    else if (launch) cnt_d = xfer_len;
    else if (xfer)   cnt_d = cnt_q - 1'b1;
    else             cnt_d = cnt_wdata;

    stat_en = complete | launch | irq_ack | wr_ok;
    if (complete)    stat_d = cmd_done ? ({5'b0, PH_STATUS} | STAT_TC) : (stat_q | STAT_TC);
    else if (launch) stat_d = {5'b0, launch_phase};
    else             stat_d = stat_q & ~STAT_TC;

    intr_en = complete | irq_ack;
    intr_d  = complete ? INTR_BUS_SVC : 8'h00;
    irq_d   = complete;

    aux_en  = complete | aux_wr;
    seq_d   = complete ? 3'b000 : aux_seq;
    flags_d = complete ? 5'b00000 : aux_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stat_q  <= '0;
      intr_q  <= '0;
      seq_q   <= '0;
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (stat_en) stat_q <= stat_d;
      if (intr_en) begin
        intr_q <= intr_d;
        irq    <= irq_d;
      end
      if (aux_en) begin
        seq_q   <= seq_d;
        flags_q <= flags_d;
      end
    end
  end
endmodule

// File: rtl/dte_engine.sv
`timescale 1ns/1ps
module dte_engine
  import dte_pkg::*;
#(
  parameter int CNT_W    = 24,
  parameter int PEND_W   = 20,
  parameter int DATA_W   = 8,
  parameter int CMD_MAX  = 32,
  parameter int ZERO_LEN = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              start,
  input  logic              cmd_phase,
  input  logic              dma_en,
  input  logic [PEND_W-1:0] pend_len,
  input  logic              cmd_done,
  input  logic              chunk_evt,
  input  logic              irq_ack,
  input  logic              aux_wr,
  input  logic [2:0]        aux_seq,
  input  logic [4:0]        aux_flags,
  input  logic              mem_in_valid,
  input  logic [DATA_W-1:0] mem_in_data,
  output logic              mem_in_ready,
  output logic              tgt_out_valid,
  output logic [DATA_W-1:0] tgt_out_data,
  input  logic              tgt_out_ready,
  input  logic              tgt_in_valid,
  input  logic [DATA_W-1:0] tgt_in_data,
  output logic              tgt_in_ready,
  output logic              mem_out_valid,
  output logic [DATA_W-1:0] mem_out_data,
  input  logic              mem_out_ready,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [7:0]        stat_q,
  output logic [7:0]        intr_q,
  output logic [2:0]        seq_q,
  output logic [4:0]        flags_q,
  output logic              irq
);
  logic              rst_meta, rst_sync_n;
  logic [CNT_W-1:0]  xfer_len, burst_len;
  logic [PEND_W-1:0] pend_mag;
  logic              to_tgt_in, to_tgt_q;
  logic              launch, complete, busy, run_act, xfer;
  logic [2:0]        launch_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  dte_len_calc #(
    .CNT_W(CNT_W), .PEND_W(PEND_W), .CMD_MAX(CMD_MAX), .ZERO_LEN(ZERO_LEN)
  ) u_len (
    .cnt(cnt_q), .pend(pend_len), .cmd_phase(cmd_phase),
    .xfer_len(xfer_len), .burst_len(burst_len), .pend_mag(pend_mag), .to_tgt(to_tgt_in)
  );

  dte_ctrl #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .dma_en(dma_en),
    .cmd_done(cmd_done), .chunk_evt(chunk_evt), .xfer(xfer),
    .cmd_phase(cmd_phase), .to_tgt_in(to_tgt_in), .burst_len(burst_len),
    .pend_mag(pend_mag), .launch(launch), .complete(complete), .busy(busy),
    .run_act(run_act), .to_tgt_q(to_tgt_q)
  );

  dte_mover #(.DATA_W(DATA_W)) u_mover (
    .act(run_act), .to_tgt(to_tgt_q),
    .mem_in_valid(mem_in_valid), .mem_in_data(mem_in_data), .mem_in_ready(mem_in_ready),
    .tgt_out_valid(tgt_out_valid), .tgt_out_data(tgt_out_data), .tgt_out_ready(tgt_out_ready),
    .tgt_in_valid(tgt_in_valid), .tgt_in_data(tgt_in_data), .tgt_in_ready(tgt_in_ready),
    .mem_out_valid(mem_out_valid), .mem_out_data(mem_out_data), .mem_out_ready(mem_out_ready),
    .xfer(xfer)
  );

  always_comb begin
    if (cmd_phase)      launch_phase = PH_CMD;
    else if (to_tgt_in) launch_phase = PH_DOUT;
    else                launch_phase = PH_DIN;
  end

  dte_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .busy(busy), .launch(launch), .xfer_len(xfer_len), .launch_phase(launch_phase),
    .xfer(xfer), .complete(complete), .cmd_done(cmd_done), .irq_ack(irq_ack),
    .aux_wr(aux_wr), .aux_seq(aux_seq), .aux_flags(aux_flags),
    .cnt_q(cnt_q), .stat_q(stat_q), .intr_q(intr_q), .seq_q(seq_q),
    .flags_q(flags_q), .irq(irq)
  );
endmodule

// File: rtl/dte_checker.sv
`timescale 1ns/1ps
module dte_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_en,
  input logic             cmd_done,
  input logic             mem_in_valid,
  input logic             mem_in_ready,
  input logic             tgt_in_valid,
  input logic             tgt_in_ready,
  input logic [CNT_W-1:0] cnt_q,
  input logic [7:0]       stat_q,
  input logic [7:0]       intr_q,
  input logic [2:0]       seq_q,
  input logic [4:0]       flags_q,
  input logic             irq
);
  logic byte_moved;
  assign byte_moved = (mem_in_valid && mem_in_ready) || (tgt_in_valid && tgt_in_ready);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_moved && !cmd_done) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r11_hold_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !(mem_in_ready || tgt_in_ready));

  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_in_ready && tgt_in_ready));

  a_r6_tc_clear_moving: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_in_ready || tgt_in_ready) |-> !stat_q[4]);

  a_r7_done_image: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (intr_q == 8'h10 && cnt_q == '0 && seq_q == 3'b000 &&
                    flags_q == 5'b00000 && stat_q[4]));
endmodule

bind dte_engine dte_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_dte_engine.sv
`timescale 1ns/100ps
module tb_dte_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_wr, start, cmd_phase, dma_en, cmd_done, chunk_evt, irq_ack, aux_wr;
  logic [23:0] cnt_wdata;
  logic [19:0] pend_len;
  logic [2:0]  aux_seq;
  logic [4:0]  aux_flags;
  logic        mem_in_valid, mem_in_ready, tgt_out_valid, tgt_out_ready;
  logic        tgt_in_valid, tgt_in_ready, mem_out_valid, mem_out_ready;
  logic [7:0]  mem_in_data, tgt_out_data, tgt_in_data, mem_out_data;
  logic [23:0] cnt_q;
  logic [7:0]  stat_q, intr_q;
  logic [2:0]  seq_q;
  logic [4:0]  flags_q;
  logic        irq;

  always #2 clk = ~clk;

  dte_engine dut (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .start(start),
    .cmd_phase(cmd_phase), .dma_en(dma_en), .pend_len(pend_len), .cmd_done(cmd_done),
    .chunk_evt(chunk_evt), .irq_ack(irq_ack), .aux_wr(aux_wr), .aux_seq(aux_seq),
    .aux_flags(aux_flags), .mem_in_valid(mem_in_valid), .mem_in_data(mem_in_data),
    .mem_in_ready(mem_in_ready), .tgt_out_valid(tgt_out_valid), .tgt_out_data(tgt_out_data),
    .tgt_out_ready(tgt_out_ready), .tgt_in_valid(tgt_in_valid), .tgt_in_data(tgt_in_data),
    .tgt_in_ready(tgt_in_ready), .mem_out_valid(mem_out_valid), .mem_out_data(mem_out_data),
    .mem_out_ready(mem_out_ready), .cnt_q(cnt_q), .stat_q(stat_q), .intr_q(intr_q),
    .seq_q(seq_q), .flags_q(flags_q), .irq(irq)
  );

  int         n_chk = 0;
  int         n_bad = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pop_cmp(input logic [7:0] got);
    logic [7:0] e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R5 unexpected byte: actual 0x%0h expected none", got);
    end else begin
      e = exp_q.pop_front();
      if (got !== e) begin
        n_bad++;
        $display("FAIL R5 byte order: actual 0x%0h expected 0x%0h", got, e);
      end
    end
  endtask

  // scoreboard monitor: sink side handshakes
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mem_out_valid && mem_out_ready) pop_cmp(mem_out_data);
      if (tgt_out_valid && tgt_out_ready) pop_cmp(tgt_out_data);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input logic [23:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic go(input logic [19:0] p, input logic c);
    pend_len = p; cmd_phase = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_done();
    cmd_done = 1'b1; @(negedge clk); cmd_done = 1'b0;
  endtask

  task automatic pulse_chunk();
    chunk_evt = 1'b1; @(negedge clk); chunk_evt = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  // driver: offers n bytes on the source side, pushes each accepted byte
  task automatic send(input int n, input logic to_tgt, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      if (to_tgt) begin mem_in_valid = 1'b1; mem_in_data = seed + 8'(i); end
      else        begin tgt_in_valid = 1'b1; tgt_in_data = seed + 8'(i); end
      #0.5;
      while (!(to_tgt ? mem_in_ready : tgt_in_ready)) begin
        @(negedge clk);
        #0.5;
      end
      exp_q.push_back(seed + 8'(i));
      @(negedge clk);
    end
    mem_in_valid = 1'b0;
    tgt_in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cnt_wr = 0; start = 0; cmd_phase = 0; dma_en = 1; cmd_done = 0;
    chunk_evt = 0; irq_ack = 0; aux_wr = 0; cnt_wdata = '0; pend_len = '0;
    aux_seq = '0; aux_flags = '0; mem_in_valid = 0; mem_in_data = '0;
    tgt_in_valid = 0; tgt_in_data = '0; tgt_out_ready = 1; mem_out_ready = 1;
    step(3);
    rst_n = 1'b1;
    step(4);
    chk("reset cnt", 32'(cnt_q), 0);
    chk("reset stat", 32'(stat_q), 0);
    chk("reset intr", 32'(intr_q), 0);
    chk("reset irq", 32'(irq), 0);

    // from target, pend exhausted -> deferred until chunk event
    prog(24'd5);
    go(20'd3, 1'b0);
    chk("R6 launch stat din", 32'(stat_q), 32'h01);
    chk("R2 cnt after launch", 32'(cnt_q), 5);
    send(3, 1'b0, 8'hA0);
    chk("R2 cnt after burst", 32'(cnt_q), 2);
    step(3);
    chk("R9 deferred irq low", 32'(irq), 0);
    chk("R9 deferred cnt", 32'(cnt_q), 2);
    prog(24'd99);
    chk("R14 busy write ignored", 32'(cnt_q), 2);
    pulse_chunk();
    chk("R7 irq", 32'(irq), 1);
    chk("R7 intr", 32'(intr_q), 32'h10);
    chk("R7 cnt zero", 32'(cnt_q), 0);
    chk("R7 stat tc", 32'(stat_q), 32'h11);
    ack();
    chk("R13 irq low", 32'(irq), 0);
    chk("R13 intr clear", 32'(intr_q), 0);
    chk("R13 tc clear", 32'(stat_q), 32'h01);

    // from target, pend remains -> immediate completion
    aux_wr = 1'b1; aux_seq = 3'd5; aux_flags = 5'd9;
    @(negedge clk); aux_wr = 1'b0;
    chk("R7 seq loaded", 32'(seq_q), 5);
    prog(24'd4);
    go(20'd10, 1'b0);
    send(4, 1'b0, 8'h10);
    chk("R8 still busy at last byte", 32'(cnt_q), 0);
    chk("R8 no irq yet", 32'(irq), 0);
    step(1);
    chk("R8 immediate irq", 32'(irq), 1);
    chk("R8 stat", 32'(stat_q), 32'h11);
    chk("R7 seq zeroed", 32'(seq_q), 0);
    chk("R7 flags zeroed", 32'(flags_q), 0);
    ack();

    // to target, deferred, ended by command complete
    prog(24'd8);
    go(20'hFFFFE, 1'b0);
    chk("R6 launch stat dout", 32'(stat_q), 32'h00);
    tgt_in_valid = 1'b1;
    #0.5;
    chk("R4 from-target stream blocked", 32'(tgt_in_ready), 0);
    tgt_in_valid = 1'b0;
    @(negedge clk);
    send(2, 1'b1, 8'h55);
    chk("R4 cnt after two", 32'(cnt_q), 6);
    step(3);
    chk("R9 to-target deferred", 32'(irq), 0);
    pulse_done();
    chk("R12 stat status phase", 32'(stat_q), 32'h13);
    chk("R12 irq", 32'(irq), 1);
    chk("R12 cnt zero", 32'(cnt_q), 0);
    ack();

    // zero count means 65536; waiting with no data
    prog(24'd0);
    go(20'd5, 1'b0);
    chk("R1 zero count length", 32'(cnt_q), 32'h10000);
    step(5);
    chk("R10 waiting busy cnt", 32'(cnt_q), 32'h10000);
    chk("R10 waiting no irq", 32'(irq), 0);
    send(5, 1'b0, 8'h30);
    chk("R1 cnt after five", 32'(cnt_q), 32'hFFFB);
    pulse_done();
    chk("R12 irq second", 32'(irq), 1);
    ack();

    // command phase: 32 byte cap, toward target
    prog(24'd100);
    go(20'd0, 1'b1);
    chk("R6 launch stat cmd", 32'(stat_q), 32'h02);
    send(32, 1'b1, 8'h80);
    chk("R3 cnt after 32", 32'(cnt_q), 68);
    chk("R3 irq not yet", 32'(irq), 0);
    step(1);
    chk("R3 completes", 32'(irq), 1);
    chk("R3 stat", 32'(stat_q), 32'h12);
    cmd_phase = 1'b0;
    ack();

    // held start while DMA disabled
    dma_en = 1'b0;
    prog(24'd3);
    go(20'd3, 1'b0);
    chk("R11 held cnt not launched", 32'(cnt_q), 3);
    tgt_in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #0.5;
      chk("R11 no move while disabled", 32'(tgt_in_ready), 0);
      @(negedge clk);
    end
    tgt_in_valid = 1'b0;
    prog(24'd7);
    chk("R14 held write ignored", 32'(cnt_q), 3);
    dma_en = 1'b1;
    @(negedge clk);
    chk("R11 replay launched", 32'(stat_q), 32'h01);
    send(3, 1'b0, 8'hC0);
    chk("R11 replay moved", 32'(cnt_q), 0);
    pulse_done();
    chk("R12 stat third", 32'(stat_q), 32'h13);
    ack();

    step(2);
    chk("R5 scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule